// File: doc/BRIEF.md
# Banked Interrupt Distributor Register File

This block stores the per-line state of an interrupt distributor and exposes it through a small register bus. It serves up to 64 interrupt lines shared by two processors. For each line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority, a processor target mask and two configuration bits. Lines 0 to 31 are private to each processor. Each processor has its own copy of their enable, pending and active bits and their priority bytes. The processor number that comes with each bus access picks the copy that the access reaches. Lines 32 and up have one shared copy.

The three bit arrays (enable, pending, active) each have two address windows. A write to the first window sets the bits written as ones. A write to the second window clears those bits. A read from either window returns the stored word. Priority and target state is one byte per line and can be reached with 1-, 2- or 4-byte accesses. Peripheral request inputs set the pending bits of shared lines directly. Priority arbitration and delivery to processors are handled by other blocks, which read this state.

Top module: `intdist_regs`

## Requirements
- R1: After a synchronous active-low reset, all stored state is zero, and every bit-array, priority and configuration read returns zero.
- R2: The bit arrays use these set/clear window pairs: enable at 0x100/0x180, pending at 0x200/0x280, active at 0x300/0x380. Word w sits at base + 4*w and covers lines 32*w to 32*w+31, with bit b holding line 32*w+b. A set write ORs the data into the word. A clear write removes the bits that are one in the data. A read from either window returns the word.
- R3: In a pending write to word 0, data bits 0 to 15 (the software-generated lines) are ignored. Bits 16 to 31 update normally.
- R4: The priority byte of line L is at 0x400 + L. A bus_size of 1, 2 or 4 (the value is the byte count) reaches lines offset+k for data byte k, k < size. Bytes above the access size read as zero. Lines at or above 64 read as zero, and writes to them are ignored.
- R5: In the priority or target window, a bus_size other than 1, 2 or 4 raises bus_err in the same cycle (combinational), writes nothing and reads zero.
- R6: The target byte of line L is at 0x800 + L, and its low 2 bits are stored (the upper bits read as zero). For L < 32, writes are ignored and reads return the one-hot mask of the requesting processor (bit bus_cpu set).
- R7: Word 0 of enable, pending and active, and the priority bytes of lines 0 to 31, are banked by bus_cpu. Word 1 and the priority bytes of lines 32 to 63 are shared by all processors.
- R8: When periph_irq[N] is high for N >= 32, pending bit N is set at the next clock edge. This takes precedence over a clear write in the same cycle. periph_irq bits below 32 have no effect.
- R9: Configuration word i is at 0xC00 + 4*i. For i < 4 the full 32-bit value is stored as written. Words 4 and above read as zero.
- R10: Offsets outside the mapped windows, and bit-array words with index 2 or above, read as zero and ignore writes. In bit-array windows, address bits 1:0 and bus_size are ignored, so the access acts on the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset into the register space |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, byte k in bits 8k+7:8k |
| bus_cpu | input | 1 | Requesting processor number, selects the banked copy |
| bus_rdata | output | 32 | Combinational read data for the current address |
| bus_err | output | 1 | Illegal access size in a byte-per-line window |
| periph_irq | input | 64 | Peripheral requests, one per line |

## Verification
A seeded random mix of writes is sent to every window, from both processor numbers and with legal and illegal sizes, and each write is followed by a read-back. Because the read-back may use the other processor number, the run separates banked state from shared state. Directed cases cover the protection of the software-generated pending bits, sub-word access to bit arrays, the fixed target bytes of private lines, and a peripheral request that arrives in the same cycle as a clear of the same word. Multi-byte priority accesses that run past line 63 check that the lane-to-line mapping stops at the edge of the array.

// File: rtl/intdist_pkg.sv
// Shared decode types and helpers for the interrupt distributor register file.
// Assumes a 12-bit byte offset; windows are selected by offset bits 11:8.
package intdist_pkg;

    typedef enum logic [2:0] {
        WIN_NONE, WIN_ENABLE, WIN_PEND, WIN_ACTIVE, WIN_PRIO, WIN_TGT, WIN_CFG
    } win_e;

    typedef struct packed {
        win_e win;
        logic clr;
    } dec_t;

    // Map an offset to its window and set/clear alias.
    function automatic dec_t decode(input logic [11:0] off);
        dec_t d;
        d.win = WIN_NONE;
        d.clr = off[7];
        case (off[11:8])
            4'h1: d.win = WIN_ENABLE;
            4'h2: d.win = WIN_PEND;
            4'h3: d.win = WIN_ACTIVE;
            4'h4, 4'h5, 4'h6, 4'h7: d.win = WIN_PRIO;
            4'h8, 4'h9, 4'hA, 4'hB: d.win = WIN_TGT;
            4'hC: d.win = WIN_CFG;
            default: d.win = WIN_NONE;
        endcase
        return d;
    endfunction

    // Legal byte-window access sizes.
    function automatic logic size_ok(input logic [2:0] s);
        return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
    endfunction

endpackage

// File: rtl/intdist_bitmap.sv
// One set/clear bit array. Word 0 is banked per processor and words 1..NUM_WORDS-1
// are shared. LOCK_MASK bits of word 0 are immune to bus writes. With HAS_INPUT,
// line_in sets bits in the shared words and wins over a clear in the same cycle.
// Assumes NUM_CPUS >= 2 and NUM_WORDS >= 2.
module intdist_bitmap #(
    parameter int          NUM_CPUS  = 2,
    parameter int          NUM_WORDS = 2,
    parameter logic [31:0] LOCK_MASK = '0,
    parameter bit          HAS_INPUT = 1'b0,
    localparam int         CPU_W     = $clog2(NUM_CPUS),
    localparam int         PHYS      = NUM_CPUS + NUM_WORDS - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_set,
    input  logic                    wr_clr,
    input  logic [4:0]              wr_word,
    input  logic [31:0]             wr_data,
    input  logic [CPU_W-1:0]        cpu,
    input  logic [4:0]              rd_word,
    output logic [31:0]             rd_data,
    input  logic [NUM_WORDS*32-1:0] line_in
);

    logic [31:0] st_q [PHYS];
    logic [31:0] st_d [PHYS];
    logic        unused_line_in;

    assign unused_line_in = ^line_in[31:0];

    // Next state of every physical word: bus set/clear, then input requests.
    always_comb begin
        for (int p = 0; p < PHYS; p++) begin
            int          w;
            logic        hit;
            logic [31:0] msk;
            w   = (p < NUM_CPUS) ? 0 : p - NUM_CPUS + 1;
            hit = (wr_word == 5'(w)) && ((p >= NUM_CPUS) || (cpu == CPU_W'(p)));
            msk = (w == 0) ? (wr_data & ~LOCK_MASK) : wr_data;
            st_d[p] = st_q[p];
            if (hit && wr_set) st_d[p] = st_d[p] | msk;
            if (hit && wr_clr) st_d[p] = st_d[p] & ~msk;
            if (HAS_INPUT && (w > 0)) st_d[p] = st_d[p] | line_in[w*32 +: 32];
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHYS; p++) st_q[p] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read port: banked word 0 by processor, shared words above, zero past the end.
    always_comb begin
        rd_data = '0;
        if (rd_word == 5'd0)
            rd_data = st_q[int'(cpu)];
        else if (int'(rd_word) < NUM_WORDS)
            rd_data = st_q[NUM_CPUS + int'(rd_word) - 1];
    end

    for (genvar p = 0; p < PHYS; p++) begin : g_chk
        if (p < NUM_CPUS) begin : g_bank
            if (LOCK_MASK != 32'd0) begin : g_lock
                a_r3_locked_bits_stay: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> $stable(st_q[p] & LOCK_MASK));
            end
            a_r7_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr_set || wr_clr) && (wr_word == 5'd0) && (cpu != CPU_W'(p)))
                |=> $stable(st_q[p]));
        end else begin : g_shared
            localparam int W = p - NUM_CPUS + 1;
            if (HAS_INPUT) begin : g_in
                a_r8_input_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
                    (line_in[W*32 +: 32] != 32'd0)
                    |=> ((st_q[p] & $past(line_in[W*32 +: 32])) == $past(line_in[W*32 +: 32])));
            end else begin : g_noin
                a_r2_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_clr && (wr_word == 5'(W)))
                    |=> ((st_q[p] & $past(wr_data)) == 32'd0));
            end
        end
    end

endmodule

// File: rtl/intdist_bytes.sv
// One byte-per-line array reached by 1/2/4-byte accesses (byte k -> line+k).
// BANKED=1: lines below BANKED_LINES have a private copy per processor.
// BANKED=0: lines below BANKED_LINES are fixed: writes ignored, reads give the
// requester's one-hot mask. Assumes WIDTH <= 8 and nbytes already validated.
module intdist_bytes #(
    parameter int NUM_CPUS     = 2,
    parameter int NUM_LINES    = 64,
    parameter int BANKED_LINES = 32,
    parameter int WIDTH        = 8,
    parameter bit BANKED       = 1'b1,
    localparam int CPU_W       = $clog2(NUM_CPUS),
    localparam int GL          = NUM_LINES - BANKED_LINES,
    localparam int GI_W        = $clog2(GL),
    localparam int LB_W        = $clog2(BANKED_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [9:0]       line,
    input  logic [2:0]       nbytes,
    input  logic [31:0]      wdata,
    input  logic [CPU_W-1:0] cpu,
    output logic [31:0]      rdata
);

    logic [WIDTH-1:0] glob_q [GL];
    logic [10:0]      lk     [4];
    logic [WIDTH-1:0] low_rd [4];
    logic             wr_g   [4];
    logic             wr_b   [4];
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    // Line addressed by each byte lane and which storage it writes.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            lk[k]   = 11'(line) + 11'(k);
            wr_g[k] = we && (3'(k) < nbytes) && (int'(lk[k]) >= BANKED_LINES)
                      && (int'(lk[k]) < NUM_LINES);
            wr_b[k] = we && (3'(k) < nbytes) && (int'(lk[k]) < BANKED_LINES);
        end
    end

    // Shared lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GL; i++) glob_q[i] <= '0;
        end else begin
            for (int k = 0; k < 4; k++)
                if (wr_g[k]) glob_q[GI_W'(lk[k] - 11'(BANKED_LINES))] <= wdata[8*k +: WIDTH];
        end
    end

    if (BANKED) begin : g_banked
        logic [BANKED_LINES-1:0][WIDTH-1:0] priv_q [NUM_CPUS];

        // Private lines of the requesting processor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int c = 0; c < NUM_CPUS; c++) priv_q[c] <= '0;
            end else begin
                for (int k = 0; k < 4; k++)
                    if (wr_b[k]) priv_q[int'(cpu)][lk[k][LB_W-1:0]] <= wdata[8*k +: WIDTH];
            end
        end

        // Private read lanes.
        always_comb begin
            for (int k = 0; k < 4; k++) low_rd[k] = priv_q[int'(cpu)][lk[k][LB_W-1:0]];
        end

        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
            a_r7_prio_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (we && (cpu != CPU_W'(c))) |=> $stable(priv_q[c]));
        end
    end else begin : g_fixed
        logic unused_wr_b;
        assign unused_wr_b = wr_b[0] ^ wr_b[1] ^ wr_b[2] ^ wr_b[3];

        // Private lines always target only the requester.
        always_comb begin
            for (int k = 0; k < 4; k++) low_rd[k] = WIDTH'(1) << cpu;
        end
    end

    // Assemble read lanes; lanes beyond the size or past the last line are zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (3'(k) < nbytes) begin
                if (int'(lk[k]) < BANKED_LINES)
                    rdata[8*k +: 8] = 8'(low_rd[k]);
                else if (int'(lk[k]) < NUM_LINES)
                    rdata[8*k +: 8] = 8'(glob_q[GI_W'(lk[k] - 11'(BANKED_LINES))]);
            end
        end
    end

endmodule

// File: rtl/intdist_regs.sv
// Top of the interrupt distributor register file: address decode, three banked
// set/clear bit arrays, priority and target byte arrays, configuration words
// and the read multiplexer. Reads are combinational; writes land at the clock
// edge when bus_we is high. Assumes 32 private lines and NUM_LINES a multiple of 32.
module intdist_regs #(
    parameter int  NUM_CPUS  = 2,
    parameter int  NUM_LINES = 64,
    parameter int  SGI_LINES = 16,
    localparam int CPU_W     = $clog2(NUM_CPUS),
    localparam int PRIV      = 32,
    localparam int NUM_WORDS = NUM_LINES / 32,
    localparam int CFG_WORDS = NUM_LINES / 16,
    localparam logic [31:0] SGI_MASK = 32'((64'd1 << SGI_LINES) - 64'd1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_we,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    input  logic [CPU_W-1:0]     bus_cpu,
    output logic [31:0]          bus_rdata,
    output logic                 bus_err,
    input  logic [NUM_LINES-1:0] periph_irq
);
    import intdist_pkg::*;

    dec_t        dec;
    logic [4:0]  word_idx;
    logic [5:0]  cfg_idx;
    logic [2:0]  nbytes;
    logic        byte_win;
    logic [31:0] rd_en, rd_pend, rd_act, rd_pri, rd_tgt;
    logic [31:0] cfg_q [CFG_WORDS];
    logic        cfg_wr;

    // Decode and size checks.
    always_comb begin
        dec      = decode(bus_addr);
        word_idx = bus_addr[6:2];
        cfg_idx  = bus_addr[7:2];
        byte_win = (dec.win == WIN_PRIO) || (dec.win == WIN_TGT);
        bus_err  = byte_win && !size_ok(bus_size);
        nbytes   = size_ok(bus_size) ? bus_size : 3'd0;
        cfg_wr   = bus_we && (dec.win == WIN_CFG) && (int'(cfg_idx) < CFG_WORDS);
    end

    intdist_bitmap #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS),
                     .LOCK_MASK('0), .HAS_INPUT(1'b0)) u_enable (
        .clk(clk), .rst_n(rst_n),
        .wr_set(bus_we && dec.win == WIN_ENABLE && !dec.clr),
        .wr_clr(bus_we && dec.win == WIN_ENABLE && dec.clr),
        .wr_word(word_idx), .wr_data(bus_wdata), .cpu(bus_cpu),
        .rd_word(word_idx), .rd_data(rd_en), .line_in('0));

    intdist_bitmap #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS),
                     .LOCK_MASK(SGI_MASK), .HAS_INPUT(1'b1)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .wr_set(bus_we && dec.win == WIN_PEND && !dec.clr),
        .wr_clr(bus_we && dec.win == WIN_PEND && dec.clr),
        .wr_word(word_idx), .wr_data(bus_wdata), .cpu(bus_cpu),
        .rd_word(word_idx), .rd_data(rd_pend), .line_in(periph_irq));

    intdist_bitmap #(.NUM_CPUS(NUM_CPUS), .NUM_WORDS(NUM_WORDS),
                     .LOCK_MASK('0), .HAS_INPUT(1'b0)) u_active (
        .clk(clk), .rst_n(rst_n),
        .wr_set(bus_we && dec.win == WIN_ACTIVE && !dec.clr),
        .wr_clr(bus_we && dec.win == WIN_ACTIVE && dec.clr),
        .wr_word(word_idx), .wr_data(bus_wdata), .cpu(bus_cpu),
        .rd_word(word_idx), .rd_data(rd_act), .line_in('0));

    intdist_bytes #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .BANKED_LINES(PRIV),
                    .WIDTH(8), .BANKED(1'b1)) u_prio (
        .clk(clk), .rst_n(rst_n), .we(bus_we && dec.win == WIN_PRIO),
        .line(bus_addr[9:0]), .nbytes(nbytes), .wdata(bus_wdata), .cpu(bus_cpu),
        .rdata(rd_pri));

    intdist_bytes #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .BANKED_LINES(PRIV),
                    .WIDTH(NUM_CPUS), .BANKED(1'b0)) u_target (
        .clk(clk), .rst_n(rst_n), .we(bus_we && dec.win == WIN_TGT),
        .line(bus_addr[9:0]), .nbytes(nbytes), .wdata(bus_wdata), .cpu(bus_cpu),
        .rdata(rd_tgt));

    // Configuration words, stored as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_WORDS; i++) cfg_q[i] <= '0;
        end else if (cfg_wr) begin
            cfg_q[int'(cfg_idx)] <= bus_wdata;
        end
    end

    // Read multiplexer by window.
    always_comb begin
        bus_rdata = '0;
        case (dec.win)
            WIN_ENABLE: bus_rdata = rd_en;
            WIN_PEND:   bus_rdata = rd_pend;
            WIN_ACTIVE: bus_rdata = rd_act;
            WIN_PRIO:   bus_rdata = rd_pri;
            WIN_TGT:    bus_rdata = rd_tgt;
            WIN_CFG:    if (int'(cfg_idx) < CFG_WORDS) bus_rdata = cfg_q[int'(cfg_idx)];
            default:    bus_rdata = '0;
        endcase
    end

    a_r9_cfg_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q[int'($past(cfg_idx))] == $past(bus_wdata)));

    a_r5_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 32'd0));

endmodule

// File: tb/test_intdist_regs.sv
`timescale 1ns/1ps
module test_intdist_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic        bus_cpu = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [63:0] periph_irq = '0;

    int checks = 0;
    int failures = 0;

    // Reference model: bit arrays [array][phys] with phys 0/1 banked, 2 shared.
    logic [31:0] m_bm [3][3];
    logic [7:0]  m_pri_b [2][32];
    logic [7:0]  m_pri_g [32];
    logic [1:0]  m_tgt [32];
    logic [31:0] m_cfg [4];

    always #2.5 clk = ~clk;

    intdist_regs i_intdist_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .periph_irq(periph_irq));

    function automatic logic sz_ok(input logic [2:0] s);
        return s == 3'd1 || s == 3'd2 || s == 3'd4;
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a[11:8])
            4'h1, 4'h2, 4'h3: return (a[6:2] >= 5'd2) ? "R10" : "R7";
            4'h4, 4'h5, 4'h6, 4'h7: return "R4";
            4'h8, 4'h9, 4'hA, 4'hB: return "R6";
            4'hC: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic void model_reset();
        for (int a = 0; a < 3; a++) for (int p = 0; p < 3; p++) m_bm[a][p] = '0;
        for (int l = 0; l < 32; l++) begin
            m_pri_b[0][l] = '0; m_pri_b[1][l] = '0; m_pri_g[l] = '0; m_tgt[l] = '0;
        end
        for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [2:0] s,
                                        input logic [31:0] d, input logic c);
        int win = int'(a[11:8]);
        if (win >= 1 && win <= 3) begin
            int w = int'(a[6:2]);
            if (w < 2) begin
                int p = (w == 0) ? int'(c) : 2;
                logic [31:0] msk = d;
                if (win == 2 && w == 0) msk = msk & 32'hFFFF_0000;
                if (a[7]) m_bm[win-1][p] = m_bm[win-1][p] & ~msk;
                else      m_bm[win-1][p] = m_bm[win-1][p] | msk;
            end
        end else if (win >= 4 && win <= 11) begin
            if (sz_ok(s)) begin
                for (int k = 0; k < int'(s); k++) begin
                    int l = int'(a[9:0]) + k;
                    if (win <= 7) begin
                        if (l < 32) m_pri_b[c][l] = d[8*k +: 8];
                        else if (l < 64) m_pri_g[l-32] = d[8*k +: 8];
                    end else if (l >= 32 && l < 64) begin
                        m_tgt[l-32] = d[8*k +: 2];
                    end
                end
            end
        end else if (win == 12) begin
            if (a[7:2] < 6'd4) m_cfg[a[7:2]] = d;
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic [2:0] s,
                                               input logic c);
        logic [31:0] r = '0;
        int win = int'(a[11:8]);
        if (win >= 1 && win <= 3) begin
            int w = int'(a[6:2]);
            if (w == 0) r = m_bm[win-1][c];
            else if (w == 1) r = m_bm[win-1][2];
        end else if (win >= 4 && win <= 11) begin
            if (sz_ok(s)) begin
                for (int k = 0; k < int'(s); k++) begin
                    int l = int'(a[9:0]) + k;
                    if (win <= 7) begin
                        if (l < 32) r[8*k +: 8] = m_pri_b[c][l];
                        else if (l < 64) r[8*k +: 8] = m_pri_g[l-32];
                    end else begin
                        if (l < 32) r[8*k +: 8] = (c ? 8'h02 : 8'h01);
                        else if (l < 64) r[8*k +: 8] = {6'd0, m_tgt[l-32]};
                    end
                end
            end
        end else if (win == 12) begin
            if (a[7:2] < 6'd4) r = m_cfg[a[7:2]];
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [2:0] s,
                             input logic [31:0] d, input logic c);
        @(negedge clk);
        bus_addr = a; bus_size = s; bus_wdata = d; bus_cpu = c; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, s, d, c);
    endtask

    task automatic bus_read_check(input string req, input logic [11:0] a,
                                  input logic [2:0] s, input logic c);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; bus_size = s; bus_cpu = c;
        #1;
        check(req, $sformatf("read %h size %0d cpu %0d", a, s, c),
              bus_rdata, model_read(a, s, c));
        check("R5", $sformatf("err %h size %0d", a, s), 32'(bus_err),
              32'((a[11:8] >= 4'h4 && a[11:8] <= 4'hB) && !sz_ok(s)));
    endtask

    function automatic logic [11:0] rand_addr();
        int r = int'($urandom % 8);
        case (r)
            0: return 12'h100 + 12'(($urandom % 3) * 4) + 12'($urandom % 4) + 12'(($urandom % 2) * 12'h80);
            1: return 12'h200 + 12'(($urandom % 3) * 4) + 12'($urandom % 4) + 12'(($urandom % 2) * 12'h80);
            2: return 12'h300 + 12'(($urandom % 3) * 4) + 12'(($urandom % 2) * 12'h80);
            3, 7: return 12'h400 + 12'($urandom % 70);
            4: return 12'h800 + 12'($urandom % 70);
            5: return 12'hC00 + 12'(($urandom % 6) * 4);
            default: return (($urandom % 2) != 0) ? 12'($urandom % 256) : 12'hD00 + 12'($urandom % 768);
        endcase
    endfunction

    function automatic logic [2:0] rand_size();
        int r = int'($urandom % 6);
        case (r)
            0: return 3'd1;
            1: return 3'd2;
            2, 3: return 3'd4;
            4: return 3'd3;
            default: return 3'd0;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        bus_read_check("R1", 12'h100, 3'd4, 1'b0);
        bus_read_check("R1", 12'h204, 3'd4, 1'b1);
        bus_read_check("R1", 12'h410, 3'd4, 1'b0);
        bus_read_check("R1", 12'hC04, 3'd4, 1'b0);

        // R3: software-generated pending bits cannot be set or cleared.
        bus_write(12'h200, 3'd4, 32'hFFFF_FFFF, 1'b0);
        bus_read_check("R3", 12'h200, 3'd4, 1'b0);
        bus_write(12'h280, 3'd4, 32'hFFFF_FFFF, 1'b0);
        bus_read_check("R3", 12'h200, 3'd4, 1'b0);

        // R2: set then clear on enable word 1 through both aliases.
        bus_write(12'h104, 3'd4, 32'hA5A5_0F0F, 1'b1);
        bus_write(12'h184, 3'd4, 32'h0000_0F00, 1'b0);
        bus_read_check("R2", 12'h184, 3'd4, 1'b0);
        bus_read_check("R2", 12'h104, 3'd4, 1'b1);

        // R10: sub-word access to a bit array acts on the whole word.
        bus_write(12'h303, 3'd1, 32'h8000_0001, 1'b1);
        bus_read_check("R10", 12'h300, 3'd4, 1'b1);
        bus_read_check("R7", 12'h300, 3'd4, 1'b0);

        // R8: peripheral request on line 40 sets pending; line 5 has no effect.
        @(negedge clk);
        periph_irq[40] = 1'b1; periph_irq[5] = 1'b1;
        @(negedge clk);
        periph_irq = '0;
        m_bm[1][2] = m_bm[1][2] | 32'h0000_0100;
        bus_read_check("R8", 12'h204, 3'd4, 1'b0);
        bus_read_check("R8", 12'h200, 3'd4, 1'b0);

        // R8: a request wins over a same-cycle clear of its own bit.
        bus_write(12'h204, 3'd4, 32'h0000_F00F, 1'b0);
        @(negedge clk);
        bus_addr = 12'h284; bus_size = 3'd4; bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b1;
        periph_irq[33] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; periph_irq = '0;
        m_bm[1][2] = 32'h0000_0002;
        bus_read_check("R8", 12'h204, 3'd4, 1'b1);

        // R5: illegal sizes in byte windows.
        bus_write(12'h420, 3'd3, 32'h1122_3344, 1'b0);
        bus_read_check("R5", 12'h420, 3'd3, 1'b0);
        bus_read_check("R5", 12'h420, 3'd4, 1'b0);

        // R4: priority lanes running past the last line.
        bus_write(12'h43E, 3'd4, 32'hDDCC_BBAA, 1'b1);
        bus_read_check("R4", 12'h43E, 3'd4, 1'b0);
        bus_read_check("R4", 12'h43F, 3'd1, 1'b1);

        // R6: private-line targets are fixed, shared ones store two bits.
        bus_write(12'h81E, 3'd4, 32'hFFFF_FFFF, 1'b0);
        bus_read_check("R6", 12'h81E, 3'd4, 1'b0);
        bus_read_check("R6", 12'h81C, 3'd4, 1'b1);

        // R9: configuration words.
        bus_write(12'hC0C, 3'd4, 32'h1357_9BDF, 1'b1);
        bus_read_check("R9", 12'hC0C, 3'd4, 1'b0);
        bus_write(12'hC10, 3'd4, 32'hFFFF_FFFF, 1'b0);
        bus_read_check("R9", 12'hC10, 3'd4, 1'b0);

        // Random mix over every window with read-back from a random processor.
        for (int i = 0; i < 800; i++) begin
            logic [11:0] a;
            logic [2:0]  s;
            logic        c;
            a = rand_addr();
            s = rand_size();
            c = 1'($urandom % 2);
            bus_write(a, s, $urandom, c);
            bus_read_check(req_of(a), a, rand_size(), 1'($urandom % 2));
        end

        // Final sweep of the bit arrays from both processors (R2, R7).
        for (int a = 0; a < 3; a++) begin
            for (int w = 0; w < 3; w++) begin
                bus_read_check("R2", 12'h100 * 12'(a + 1) + 12'(w * 4), 3'd4, 1'b0);
                bus_read_check("R7", 12'h100 * 12'(a + 1) + 12'h80 + 12'(w * 4), 3'd4, 1'b1);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule